// File: doc/BRIEF.md
# Receive Ring DMA Engine

This engine drains received packets from an on-chip byte FIFO into host memory buffers. The buffers are described by a ring of descriptors that the host owns and hands over. The engine looks at how much of the packet at the head of the FIFO has arrived. It starts copying once enough bytes are present. A short frame is either discarded or copied whole, depending on a configuration bit. A packet that ends with a MAC error is thrown away, unless errors are accepted, and its descriptor is kept for the next packet. A packet that fills its buffer continues into the following descriptor.

The engine reads descriptors through a request/acknowledge read port. It writes payload bytes and descriptor status words through a request/acknowledge write port. When it meets a descriptor it does not own, it suspends and raises a buffer-unavailable interrupt. It resumes when the host issues a receive demand. A one-cycle completion interrupt marks every packet that was delivered. Counters report runts that were discarded and packets lost to FIFO overflow.

Top module: `rx_dma_engine`

## Requirements
- R1: After reset, no read or write request is raised, nothing is popped from the FIFO, both interrupts are low and both counters read zero.
- R2: While runt acceptance is off and the head packet has fewer than 64 bytes buffered and no end, no payload is written. Once 64 bytes are buffered, copying starts before the packet end arrives.
- R3: With runt acceptance off, a packet whose end arrives at fewer than 64 bytes is popped without any memory write, and runt_count rises by one.
- R4: With runt acceptance on, a packet shorter than 64 bytes is copied only after its end flag is in the FIFO.
- R5: When a valid packet ends, the engine writes word 0 of its descriptor with bit 31 (ownership) cleared, bit 29 (last) set, bit 16 set if the packet carried an accepted error, and bits 15:0 holding the byte count placed in that buffer. It then pulses irq_done for one cycle and moves to the next descriptor.
- R6: A packet that ends with fifo_err set while cfg_accept_err is low gets no status write and no irq_done. The same descriptor is used again from buffer offset 0 for the next packet.
- R7: When a fetched descriptor has bit 31 clear, the engine pulses irq_nobuf and suspends. No data is written and the FIFO is not popped while it is suspended.
- R8: A suspended engine refetches a descriptor only after rx_demand is pulsed. A descriptor that becomes owned without a demand does not resume it.
- R9: Each cycle with fifo_ovf high raises drop_count by one.
- R10: When a buffer fills before the packet ends, that descriptor is released at once with bit 30 (first) set only for the packet's first buffer and bit 29 clear. The rest of the packet continues in the next descriptor.
- R11: Descriptor i occupies 16 bytes at cfg_ring_base + 16*i: word 0 holds status and ownership, offset 4 holds the buffer address and offset 8 holds the buffer size in bits 15:0. The index wraps to 0 after RING_N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 |
| cfg_runt_ok | input | 1 | Accept packets shorter than 64 bytes |
| cfg_accept_err | input | 1 | Treat packets flagged with an error as valid |
| rx_demand | input | 1 | Host receive demand strobe |
| fifo_valid | input | 1 | FIFO head byte present |
| fifo_data | input | 8 | FIFO head byte |
| fifo_last | input | 1 | Head byte ends its packet |
| fifo_err | input | 1 | Error flag, meaningful with fifo_last |
| head_cnt | input | CW | Bytes of the head packet now buffered |
| head_end | input | 1 | The head packet's end is in the FIFO |
| fifo_ovf | input | 1 | FIFO overflow, one packet lost |
| fifo_pop | output | 1 | Remove head byte |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Read word address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data (byte in bits 7:0) |
| wr_word | output | 1 | 1 = 32-bit status write, 0 = byte write |
| wr_ack | input | 1 | Write accepted |
| irq_done | output | 1 | Packet delivered pulse |
| irq_nobuf | output | 1 | Buffer unavailable pulse |
| runt_count | output | 16 | Discarded runts |
| drop_count | output | 16 | Overflow losses |

## Verification
The assertions rely on several properties of the inputs. The memory side acknowledges only a pending request, at most once per request. The FIFO holds fifo_valid and its head byte steady until that byte is popped. head_cnt and head_end describe the same packet that is streaming at the head, and every buffer size is nonzero. The bench's FIFO model derives head_cnt, head_end and the head byte from a single queue after every push and pop. Its memory model answers each request after one idle cycle. Descriptors are re-armed with sizes of 128 bytes, and error packets are kept shorter than a buffer so that a rewind never follows a spill.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_OWN, S_ADDR, S_SIZE, S_SUSP, S_MOVE, S_DROP, S_WB
    } rx_state_e;

    localparam int OWN_BIT   = 31;
    localparam int FIRST_BIT = 30;
    localparam int LAST_BIT  = 29;
    localparam int ERR_BIT   = 16;

    typedef struct packed {
        logic        first;
        logic        last;
        logic        err;
        logic [15:0] count;
    } rx_stat_t;

    function automatic logic [31:0] pack_status(input rx_stat_t s);
        logic [31:0] w;
        w = '0;
        w[FIRST_BIT] = s.first;
        w[LAST_BIT]  = s.last;
        w[ERR_BIT]   = s.err;
        w[15:0]      = s.count;
        return w;
    endfunction
endpackage

// File: rtl/rxdma_start.sv
module rxdma_start #(
    parameter int CW     = 12,
    parameter int THRESH = 64
) (
    input  logic [CW-1:0] head_cnt,
    input  logic          head_end,
    input  logic          runt_ok,
    output logic          go_move,
    output logic          go_drop
);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);
    logic big;
    always_comb begin
        big     = head_cnt >= LIMIT;
        go_drop = head_end && !big && !runt_ok;
        go_move = big || (head_end && runt_ok);
    end
endmodule

// File: rtl/rxdma_ring.sv
module rxdma_ring #(
    parameter int RING_N = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    input  logic [31:0] base,
    output logic [31:0] desc_addr
);
    localparam int IW = (RING_N > 1) ? $clog2(RING_N) : 1;
    localparam logic [IW-1:0] TOP = IW'(RING_N - 1);
    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (adv)
            idx <= (idx == TOP) ? '0 : idx + 1'b1;
    end

    assign desc_addr = base + (32'(idx) << 4);

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx <= TOP); // R11
endmodule

// File: rtl/rx_dma_engine.sv
module rx_dma_engine
    import rxdma_pkg::*;
#(
    parameter int CW     = 12,
    parameter int THRESH = 64,
    parameter int RING_N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   cfg_ring_base,
    input  logic          cfg_runt_ok,
    input  logic          cfg_accept_err,
    input  logic          rx_demand,
    input  logic          fifo_valid,
    input  logic [7:0]    fifo_data,
    input  logic          fifo_last,
    input  logic          fifo_err,
    input  logic [CW-1:0] head_cnt,
    input  logic          head_end,
    input  logic          fifo_ovf,
    output logic          fifo_pop,
    output logic          rd_req,
    output logic [31:0]   rd_addr,
    input  logic          rd_ack,
    input  logic [31:0]   rd_data,
    output logic          wr_req,
    output logic [31:0]   wr_addr,
    output logic [31:0]   wr_data,
    output logic          wr_word,
    input  logic          wr_ack,
    output logic          irq_done,
    output logic          irq_nobuf,
    output logic [15:0]   runt_count,
    output logic [15:0]   drop_count
);
    rx_state_e   state;
    logic        have_desc, in_pkt, d_first, st_last, st_err;
    logic [31:0] buf_addr, desc_addr;
    logic [15:0] buf_size, off;
    logic        go_move, go_drop, adv;
    rx_stat_t    stat;

    rxdma_start #(.CW(CW), .THRESH(THRESH)) u_start (
        .head_cnt(head_cnt), .head_end(head_end), .runt_ok(cfg_runt_ok),
        .go_move(go_move), .go_drop(go_drop)
    );

    assign adv = (state == S_WB) && wr_ack;

    rxdma_ring #(.RING_N(RING_N)) u_ring (
        .clk(clk), .rst(rst), .adv(adv), .base(cfg_ring_base), .desc_addr(desc_addr)
    );

    always_comb begin
        stat     = '{first: d_first, last: st_last, err: st_err, count: off};
        rd_req   = 1'b0;
        rd_addr  = desc_addr;
        wr_req   = 1'b0;
        wr_addr  = desc_addr;
        wr_data  = '0;
        wr_word  = 1'b0;
        fifo_pop = 1'b0;
        case (state)
            S_OWN:  rd_req = 1'b1;
            S_ADDR: begin rd_req = 1'b1; rd_addr = desc_addr + 32'd4; end
            S_SIZE: begin rd_req = 1'b1; rd_addr = desc_addr + 32'd8; end
            S_MOVE: begin
                wr_req   = fifo_valid;
                wr_addr  = buf_addr + 32'(off);
                wr_data  = {24'd0, fifo_data};
                fifo_pop = fifo_valid && wr_ack;
            end
            S_WB: begin
                wr_req  = 1'b1;
                wr_word = 1'b1;
                wr_data = pack_status(stat);
            end
            S_DROP: fifo_pop = fifo_valid;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            have_desc  <= 1'b0;
            in_pkt     <= 1'b0;
            d_first    <= 1'b0;
            st_last    <= 1'b0;
            st_err     <= 1'b0;
            buf_addr   <= '0;
            buf_size   <= '0;
            off        <= '0;
            irq_done   <= 1'b0;
            irq_nobuf  <= 1'b0;
            runt_count <= '0;
            drop_count <= '0;
        end else begin
            irq_done  <= 1'b0;
            irq_nobuf <= 1'b0;
            if (fifo_ovf)
                drop_count <= drop_count + 16'd1;
            case (state)
                S_IDLE: begin
                    if (go_drop)
                        state <= S_DROP;
                    else if (go_move)
                        state <= have_desc ? S_MOVE : S_OWN;
                end
                S_OWN: if (rd_ack) begin
                    if (rd_data[OWN_BIT]) begin
                        state <= S_ADDR;
                    end else begin
                        state     <= S_SUSP;
                        irq_nobuf <= 1'b1;
                    end
                end
                S_ADDR: if (rd_ack) begin
                    buf_addr <= rd_data;
                    state    <= S_SIZE;
                end
                S_SIZE: if (rd_ack) begin
                    buf_size  <= rd_data[15:0];
                    have_desc <= 1'b1;
                    off       <= '0;
                    d_first   <= !in_pkt;
                    state     <= S_MOVE;
                end
                S_SUSP: if (rx_demand) state <= S_OWN;
                S_MOVE: if (fifo_valid && wr_ack) begin
                    off    <= off + 16'd1;
                    in_pkt <= 1'b1;
                    if (fifo_last) begin
                        if (fifo_err && !cfg_accept_err) begin
                            off     <= '0;
                            in_pkt  <= 1'b0;
                            d_first <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            st_last <= 1'b1;
                            st_err  <= fifo_err;
                            state   <= S_WB;
                        end
                    end else if (off + 16'd1 == buf_size) begin
                        st_last <= 1'b0;
                        st_err  <= 1'b0;
                        state   <= S_WB;
                    end
                end
                S_WB: if (wr_ack) begin
                    have_desc <= 1'b0;
                    if (st_last) begin
                        in_pkt   <= 1'b0;
                        irq_done <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        state <= S_OWN;
                    end
                end
                S_DROP: if (fifo_valid && fifo_last) begin
                    runt_count <= runt_count + 16'd1;
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_POP_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_valid); // R2
    AST_RUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (runt_count != $past(runt_count)) |-> (runt_count == $past(runt_count) + 16'd1)); // R3
    AST_DONE_AFTER_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> $past(wr_req && wr_word && wr_ack)); // R5
    AST_NOBUF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_nobuf |-> $past(rd_ack && !rd_data[OWN_BIT])); // R7
    AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (rst)
        irq_nobuf |-> (!wr_req && !fifo_pop)); // R7
    AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R11
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req)); // R11
endmodule

// File: tb/sim_rx_dma_engine.sv
module sim_rx_dma_engine;
    logic        clk = 1'b0, rst = 1'b1;
    logic [31:0] cfg_ring_base = 32'd0;
    logic        cfg_runt_ok = 1'b0, cfg_accept_err = 1'b0, rx_demand = 1'b0;
    logic        fifo_valid = 1'b0, fifo_last = 1'b0, fifo_err = 1'b0;
    logic [7:0]  fifo_data = 8'd0;
    logic [11:0] head_cnt = 12'd0;
    logic        head_end = 1'b0, fifo_ovf = 1'b0;
    logic        fifo_pop, rd_req, wr_req, wr_word, irq_done, irq_nobuf;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0, wr_ack = 1'b0;
    logic [31:0] rd_data = 32'd0;
    logic [15:0] runt_count, drop_count;

    rx_dma_engine u0 (.*);

    always #10 clk = ~clk;

    typedef struct packed { logic [7:0] d; logic l; logic e; } fb_t;
    fb_t q[$];
    logic [7:0] mem [0:1023];
    int checks = 0, fails = 0, nbyte_wr = 0, done_cnt = 0, nobuf_cnt = 0, cyc = 0;
    int exp_idx = 0, exp_runt = 0;

    function automatic logic [31:0] rdw(input logic [31:0] a);
        return {mem[a[9:0]+3], mem[a[9:0]+2], mem[a[9:0]+1], mem[a[9:0]]};
    endfunction

    task automatic wrw(input logic [31:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a[9:0]+k] = v[8*k +: 8];
    endtask

    task automatic upd();
        int n;
        logic e;
        n = 0; e = 1'b0;
        foreach (q[k]) begin
            if (!e) begin
                n++;
                if (q[k].l) e = 1'b1;
            end
        end
        fifo_valid = q.size() > 0;
        fifo_data  = fifo_valid ? q[0].d : 8'd0;
        fifo_last  = fifo_valid ? q[0].l : 1'b0;
        fifo_err   = fifo_valid ? q[0].e : 1'b0;
        head_cnt   = 12'(n);
        head_end   = e;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (fifo_pop && q.size() > 0) void'(q.pop_front());
    end

    always @(negedge clk) begin
        if (rd_req && !rd_ack) begin rd_ack = 1'b1; rd_data = rdw(rd_addr); end
        else rd_ack = 1'b0;
        if (wr_req && !wr_ack) begin
            wr_ack = 1'b1;
            if (wr_word) wrw(wr_addr, wr_data);
            else begin mem[wr_addr[9:0]] = wr_data[7:0]; nbyte_wr++; end
        end else wr_ack = 1'b0;
        if (irq_done) done_cnt++;
        if (irq_nobuf) nobuf_cnt++;
        upd();
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: act cycles=%0d exp < 150000", cyc);
        summary();
    end

    task automatic chk(input logic ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input int i);
        wrw(32'(i*16), 32'h8000_0000);
        wrw(32'(i*16+4), 32'(256 + i*128));
        wrw(32'(i*16+8), 32'd128);
    endtask

    task automatic push(input int n, input int seed, input int from, input logic endit, input logic err);
        @(negedge clk);
        for (int j = 0; j < n; j++) begin
            fb_t b;
            b.d = 8'(seed + from + j);
            b.l = endit && (j == n-1);
            b.e = err && (j == n-1);
            q.push_back(b);
        end
        upd();
    endtask

    task automatic wait_done(input int target);
        int t;
        t = 0;
        while (done_cnt < target && t < 3000) begin @(negedge clk); t++; end
        cycles(4);
    endtask

    task automatic wait_empty();
        int t;
        t = 0;
        while (q.size() > 0 && t < 3000) begin @(negedge clk); t++; end
        cycles(10);
    endtask

    // bench model of delivery: chunks of 128 bytes per descriptor
    task automatic verify(input int len, input int seed, input logic err, input string r);
        int rem, base, n, bad;
        logic [31:0] exp;
        rem = len; base = 0;
        while (rem > 0) begin
            n = (rem > 128) ? 128 : rem;
            bad = 0;
            for (int j = 0; j < n; j++)
                if (mem[256 + exp_idx*128 + j] != 8'(seed + base + j)) bad++;
            chk(bad == 0, {r, " data"}, 32'(bad), 32'd0);
            exp = 32'(n);
            if (base == 0) exp[30] = 1'b1;
            if (rem == n) begin exp[29] = 1'b1; exp[16] = err; end
            chk(rdw(32'(exp_idx*16)) == exp, {r, " status"}, rdw(32'(exp_idx*16)), exp);
            arm(exp_idx);
            exp_idx = (exp_idx + 1) % 4;
            base += n; rem -= n;
        end
    endtask

    initial begin
        int w0, d0, len, seed, runt_ok, err, acc;
        void'($urandom(1234));
        for (int i = 0; i < 1024; i++) mem[i] = 8'd0;
        for (int i = 0; i < 4; i++) arm(i);
        cycles(3);
        chk(!rd_req && !wr_req && !fifo_pop, "R1 requests", {29'd0, rd_req, wr_req, fifo_pop}, 0);
        chk(runt_count == 0 && drop_count == 0 && !irq_done && !irq_nobuf, "R1 counters",
            {runt_count, drop_count}, 0);
        @(negedge clk); rst = 1'b0;

        // R2 threshold
        push(63, 16, 0, 1'b0, 1'b0); cycles(20);
        chk(nbyte_wr == 0, "R2 below 64", 32'(nbyte_wr), 0);
        push(1, 16, 63, 1'b0, 1'b0); cycles(20);
        chk(nbyte_wr > 0, "R2 early start", 32'(nbyte_wr), 1);
        push(36, 16, 64, 1'b1, 1'b0); wait_done(1);
        verify(100, 16, 1'b0, "R5");

        // R10 spill across descriptors
        push(200, 77, 0, 1'b1, 1'b0); wait_done(2);
        verify(200, 77, 1'b0, "R10");

        // R3 runt drop
        w0 = nbyte_wr;
        push(30, 5, 0, 1'b1, 1'b0); wait_empty(); exp_runt++;
        chk(runt_count == 16'(exp_runt), "R3 runt count", 32'(runt_count), 32'(exp_runt));
        chk(nbyte_wr == w0, "R3 no writes", 32'(nbyte_wr), 32'(w0));

        // R4 runt accepted after end
        cfg_runt_ok = 1'b1;
        push(29, 9, 0, 1'b0, 1'b0); cycles(20);
        chk(nbyte_wr == w0, "R4 wait for end", 32'(nbyte_wr), 32'(w0));
        push(1, 9, 29, 1'b1, 1'b0); wait_done(3);
        verify(30, 9, 1'b0, "R4");
        chk(exp_idx == 0, "R11 wrap", 32'(exp_idx), 0);

        // R6 invalid packet reuses descriptor
        push(20, 40, 0, 1'b1, 1'b1); wait_empty();
        chk(done_cnt == 3, "R6 no done", 32'(done_cnt), 3);
        chk(rdw(0) == 32'h8000_0000, "R6 no status", rdw(0), 32'h8000_0000);
        push(40, 90, 0, 1'b1, 1'b0); wait_done(4);
        verify(40, 90, 1'b0, "R6 reuse");

        // R5 accepted error
        cfg_accept_err = 1'b1;
        push(50, 3, 0, 1'b1, 1'b1); wait_done(5);
        verify(50, 3, 1'b1, "R5 err");
        cfg_accept_err = 1'b0;

        // R7 / R8 suspend and resume
        wrw(32'(exp_idx*16), 32'd0);
        w0 = nbyte_wr;
        push(80, 120, 0, 1'b1, 1'b0); cycles(30);
        chk(nobuf_cnt == 1, "R7 nobuf irq", 32'(nobuf_cnt), 1);
        chk(nbyte_wr == w0, "R7 no data", 32'(nbyte_wr), 32'(w0));
        arm(exp_idx); cycles(20);
        chk(nbyte_wr == w0, "R8 needs demand", 32'(nbyte_wr), 32'(w0));
        @(negedge clk); rx_demand = 1'b1; @(negedge clk); rx_demand = 1'b0;
        wait_done(6);
        verify(80, 120, 1'b0, "R8");

        // R9 overflow
        @(negedge clk); fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0;
        @(negedge clk);
        chk(drop_count == 16'd1, "R9 overflow", 32'(drop_count), 1);

        // random packets
        d0 = 6;
        for (int p = 0; p < 24; p++) begin
            len = 1 + int'($urandom % 250);
            seed = int'($urandom % 256);
            runt_ok = int'($urandom % 2);
            acc = int'($urandom % 2);
            err = (len <= 100) ? int'($urandom % 3 == 0) : 0;
            cfg_runt_ok = runt_ok[0];
            cfg_accept_err = acc[0];
            push(len, seed, 0, 1'b1, err[0]);
            if (len < 64 && !runt_ok[0]) begin
                wait_empty(); exp_runt++;
                chk(runt_count == 16'(exp_runt), "R3 random", 32'(runt_count), 32'(exp_runt));
            end else if (err[0] && !acc[0]) begin
                wait_empty();
                chk(rdw(32'(exp_idx*16)) == 32'h8000_0000, "R6 random",
                    rdw(32'(exp_idx*16)), 32'h8000_0000);
            end else begin
                d0++; wait_done(d0);
                verify(len, seed, err[0], "R5 random");
            end
        end
        chk(done_cnt == d0, "R5 done count", 32'(done_cnt), 32'(d0));
        summary();
    end
endmodule